// File: doc/BRIEF.md
# Spare-stage pipeline with fault-search controller

This block is a linear pipeline of identical compute stages with a small number of extra stages held in reserve. Every stage has a pass-through path beside it, so any stage can be taken out of use. Data still moves one stage per clock, and the end-to-end latency always equals the number of physical stages. Exactly as many stages as the function needs are active at any time. The remaining stages are bypassed, and at reset those are the top spare stages.

A built-in controller locates a broken stage on request. It waits for the pipeline to empty and sends a fixed test word through it. It compares the result against a precomputed answer. If the result is wrong, it bypasses one candidate stage at a time, lowest index first, and retests until the answer is correct. The first candidate that passes is recorded as faulty for good. A tuning mode runs the same check while lowering an abstract operating-margin setting one step at a time. When a failure appears at some step, the controller tries to isolate the weak stage. If no single stage can be isolated, it raises the margin step by step until the check passes again.

The bypass selection for each stage is stored in three copies, and a majority lookup decides it, so an upset in one copy changes nothing. The stage datapath is a stand-in: a rotate-left by 5 followed by adding a fixed 32-bit constant. The fault and upset inputs model physical defects for test.

Top module: `spare_pipe`

## Requirements
- R1: After reset `out_valid`, `busy` and `failed` are 0, `margin` is all ones (7), and `bypass_map` has only the top spare stage set (5'b10000 with the default 4 working stages and 1 spare; bit j is 1 when physical stage j is bypassed).
- R2: A word accepted on `in_valid` while the block is not busy appears on `out_data` with `out_valid` exactly NLOG+NSPARE (5) cycles later. Its value is the stage step (rotate left 5, add 32'h9E3779B9) applied NLOG times. Words leave in the order they entered.
- R3: While `busy` is 1, `in_valid` is ignored and produces no output. Internal test words never appear on `out_valid`.
- R4: `bypass_map` always has exactly NSPARE bits set.
- R5: `bypass_map` changes only in a cycle that follows a cycle with no word in any stage, so words already in flight finish under the map they entered with.
- R6: A diagnosis request (`diag_start` pulse) on a fault-free pipeline returns to idle with `bypass_map`, `margin` and `failed` unchanged.
- R7: With one active stage corrupting its output (`fault_inj` bit j) and a spare unused, diagnosis ends with `bypass_map` bit j set, the unused spare now active, and correct outputs afterwards.
- R8: If diagnosis finds a wrong result and no spare is left, or no single candidate fixes it, `failed` rises and stays 1 until reset. `bypass_map` keeps its last committed value and further requests are ignored.
- R9: `margin` only changes by exactly one step at a time.
- R10: In tuning mode (`tune_start` pulse), a failure that one bypass repairs commits that stage. Lowering then continues down to margin 0.
- R11: In tuning mode, a failure that no single bypass repairs raises `margin` one step at a time until the check passes, with `bypass_map` unchanged.
- R12: Inverting one of the three stored selection copies of any stage (`sel_flip`) changes neither `bypass_map` nor the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid (ignored while busy) |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| diag_start | input | 1 | Pulse: run the test and fault search |
| tune_start | input | 1 | Pulse: run the margin-lowering loop |
| fault_inj | input | 5 | Per physical stage: corrupt that stage's computed result |
| sel_flip | input | 5 | Per physical stage: invert one stored copy of its bypass select |
| bypass_map | output | 5 | Voted bypass select per physical stage |
| margin | output | 3 | Current operating-margin setting |
| busy | output | 1 | Controller is testing, searching or tuning |
| failed | output | 1 | Unrecoverable: stages could not be repaired |

## Verification
Several rules are checked by assertions on every cycle. The bypass map always carries exactly the spare count of bits, and it only changes after an empty pipeline. The margin only moves in single steps. The committed fault set never exceeds the spare budget. The failure flag is sticky, and test results only leave the pipeline while the controller is busy. Other behaviour can only be shown by the bench's scenarios. These include the computed values and the five-cycle latency, and the correct stage being chosen when a fault is injected. They also include the failure when no spare is left, the two outcomes of the tuning loop, and the tolerance of a stored-select upset.

// File: rtl/spare_pipe_pkg.sv
// Package: shared types and constants for the spare-stage pipeline.
// Assumes: nothing beyond IEEE 1800-2017.
package spare_pipe_pkg;

    // Controller states of the test, search and tuning sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_COMPARE,
        ST_NEXT_CANDIDATE,
        ST_COMMIT,
        ST_TUNE_DOWN,
        ST_TUNE_UP,
        ST_FAIL
    } ctrl_state_e;

    // Majority of three bits as an 8-entry lookup, indexed by {a, b, c}.
    localparam logic [7:0] VOTE_LUT = 8'b1110_1000;

endpackage

// File: rtl/sp_stage.sv
// One physical pipeline stage: a registered stand-in compute step with a
// pass-through path beside it. A fault input corrupts the computed result.
// Assumes: 0 < ROT < W. Latency is one cycle whether bypassed or not.
module sp_stage #(
    parameter int          W         = 32,
    parameter int          ROT       = 5,
    parameter logic [W-1:0] STEP_K   = 32'h9E37_79B9,
    parameter logic [W-1:0] FAULT_XOR = 32'h0001_0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic         v_in,
    input  logic         t_in,
    input  logic         byp,
    input  logic         fault,
    output logic [W-1:0] d_q,
    output logic         v_q,
    output logic         t_q
);
    logic [W-1:0] work;
    logic [W-1:0] nxt;

    // Compute step, optional corruption, then the 2:1 bypass mux.
    always_comb begin
        work = ((d_in << ROT) | (d_in >> (W - ROT))) + STEP_K;
        if (fault) work = work ^ FAULT_XOR;
        nxt = byp ? d_in : work;
    end

    // Stage register for data, valid and test tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
            t_q <= 1'b0;
        end else begin
            d_q <= nxt;
            v_q <= v_in;
            t_q <= t_in;
        end
    end
endmodule

// File: rtl/sp_bypass_sel.sv
// Bypass select store: three copies of each stage's select bit, loaded only
// when the pipeline is empty and decided by a majority lookup.
// Assumes: 'want' always carries exactly NSPARE set bits.
module sp_bypass_sel
    import spare_pipe_pkg::*;
#(
    parameter int NPHYS  = 5,
    parameter int NSPARE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPHYS-1:0] want,
    input  logic [NPHYS-1:0] flip,
    output logic [NPHYS-1:0] map
);
    localparam int NLOG = NPHYS - NSPARE;
    localparam logic [NPHYS-1:0] DEF_MAP = {{NSPARE{1'b1}}, {NLOG{1'b0}}};

    for (genvar j = 0; j < NPHYS; j++) begin : g_bit
        logic ca, cb, cc;

        // Hold three copies of this stage's select; update only when drained.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ca <= DEF_MAP[j];
                cb <= DEF_MAP[j];
                cc <= DEF_MAP[j];
            end else if (load) begin
                ca <= want[j];
                cb <= want[j];
                cc <= want[j];
            end
        end

        // Copy a may be upset; the 8-entry vote hides a single bad copy.
        assign map[j] = VOTE_LUT[{ca ^ flip[j], cb, cc}];
    end

    // R4: the voted map always bypasses exactly the spare count of stages.
    p_spare_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(map) == NSPARE);
endmodule

// File: rtl/sp_diag_ctrl.sv
// Test, search and tuning sequencer. It sends a fixed test word through the
// emptied pipeline and compares the result. On a mismatch it bypasses one
// candidate stage at a time and commits the first one that passes. In tuning
// mode it lowers the margin until a failure appears, then isolates the weak
// stage or raises the margin again.
// Assumes: the test result returns on res_valid after launch; NSPARE < NPHYS.
module sp_diag_ctrl
    import spare_pipe_pkg::*;
#(
    parameter int           W        = 32,
    parameter int           NPHYS    = 5,
    parameter int           NSPARE   = 1,
    parameter int           MW       = 3,
    parameter logic [W-1:0] TEST_EXP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diag_start,
    input  logic             tune_start,
    input  logic             pipe_empty,
    input  logic             res_valid,
    input  logic [W-1:0]     res_data,
    input  logic [NPHYS-1:0] applied_map,
    output logic [NPHYS-1:0] want_map,
    output logic             test_fire,
    output logic             busy,
    output logic             failed,
    output logic [MW-1:0]    margin
);
    localparam int NLOG = NPHYS - NSPARE;
    localparam int SW   = $clog2(NPHYS + 1);
    localparam logic [MW-1:0] MAXM = {MW{1'b1}};

    ctrl_state_e      state_q;
    logic [NPHYS-1:0] bad_q;
    logic [SW-1:0]    cand_q, scan_q;
    logic             cand_on_q, tune_q, settle_q, launched_q;
    logic [W-1:0]     res_q;
    logic [MW-1:0]    margin_q;
    logic [NPHYS-1:0] skip_set;
    int               kept;

    // Requested map: committed faults plus candidate; first NLOG others active.
    always_comb begin
        kept = 0;
        for (int j = 0; j < NPHYS; j++) begin
            skip_set[j] = bad_q[j] | (cand_on_q && (cand_q == SW'(j)));
            if (!skip_set[j] && kept < NLOG) begin
                want_map[j] = 1'b0;
                kept = kept + 1;
            end else begin
                want_map[j] = 1'b1;
            end
        end
    end

    // Launch the test word only into an empty pipeline with the map applied.
    assign test_fire = (state_q == ST_TEST) && !launched_q && pipe_empty &&
                       (applied_map == want_map);
    assign busy   = (state_q != ST_IDLE) && (state_q != ST_FAIL);
    assign failed = (state_q == ST_FAIL);
    assign margin = margin_q;

    // Sequencer state, fault record, candidate scan and margin setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bad_q      <= '0;
            cand_q     <= '0;
            scan_q     <= '0;
            cand_on_q  <= 1'b0;
            tune_q     <= 1'b0;
            settle_q   <= 1'b0;
            launched_q <= 1'b0;
            res_q      <= '0;
            margin_q   <= MAXM;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (diag_start) begin
                        tune_q   <= 1'b0;
                        settle_q <= 1'b0;
                        state_q  <= ST_TEST;
                    end else if (tune_start) begin
                        tune_q   <= 1'b1;
                        settle_q <= 1'b0;
                        state_q  <= ST_TUNE_DOWN;
                    end
                end
                ST_TEST: begin
                    if (test_fire) begin
                        launched_q <= 1'b1;
                    end else if (launched_q && res_valid) begin
                        res_q      <= res_data;
                        launched_q <= 1'b0;
                        state_q    <= ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    if (res_q == TEST_EXP) begin
                        if (cand_on_q)              state_q <= ST_COMMIT;
                        else if (tune_q && !settle_q) state_q <= ST_TUNE_DOWN;
                        else                        state_q <= ST_IDLE;
                    end else if (cand_on_q) begin
                        state_q <= ST_NEXT_CANDIDATE;
                    end else if (settle_q) begin
                        state_q <= ST_TUNE_UP;
                    end else if ($countones(bad_q) < NSPARE) begin
                        scan_q  <= '0;
                        state_q <= ST_NEXT_CANDIDATE;
                    end else begin
                        state_q <= tune_q ? ST_TUNE_UP : ST_FAIL;
                    end
                end
                ST_NEXT_CANDIDATE: begin
                    if (scan_q == SW'(NPHYS)) begin
                        cand_on_q <= 1'b0;
                        state_q   <= tune_q ? ST_TUNE_UP : ST_FAIL;
                    end else if (bad_q[scan_q]) begin
                        scan_q <= scan_q + 1'b1;
                    end else begin
                        cand_q    <= scan_q;
                        cand_on_q <= 1'b1;
                        scan_q    <= scan_q + 1'b1;
                        state_q   <= ST_TEST;
                    end
                end
                ST_COMMIT: begin
                    bad_q[cand_q] <= 1'b1;
                    cand_on_q     <= 1'b0;
                    state_q       <= tune_q ? ST_TUNE_DOWN : ST_IDLE;
                end
                ST_TUNE_DOWN: begin
                    if (margin_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        margin_q <= margin_q - 1'b1;
                        state_q  <= ST_TEST;
                    end
                end
                ST_TUNE_UP: begin
                    settle_q <= 1'b1;
                    if (margin_q == MAXM) begin
                        state_q <= ST_FAIL;
                    end else begin
                        margin_q <= margin_q + 1'b1;
                        state_q  <= ST_TEST;
                    end
                end
                default: state_q <= ST_FAIL;
            endcase
        end
    end

    // R8: never more committed faults than spares.
    p_spare_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bad_q) <= NSPARE);

    // R8: the unrecoverable status holds until reset.
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        failed |=> failed);

    // R9: the margin moves by exactly one step when it moves.
    p_margin_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_q != $past(margin_q)) |->
        ((margin_q == MW'($past(margin_q) + 1'b1)) ||
         (margin_q == MW'($past(margin_q) - 1'b1))));
endmodule

// File: rtl/spare_pipe.sv
// Top: a chain of NLOG+NSPARE identical stages with per-stage bypass, the
// voted select store and the diagnosis/tuning controller. User words enter
// only while the controller is idle or failed; test words are tagged and
// kept off the output.
// Assumes: fault_inj and sel_flip model defects and are 0 in normal use.
module spare_pipe
    import spare_pipe_pkg::*;
#(
    parameter int           W         = 32,
    parameter int           NLOG      = 4,
    parameter int           NSPARE    = 1,
    parameter int           MW        = 3,
    parameter int           ROT       = 5,
    parameter logic [W-1:0] STEP_K    = 32'h9E37_79B9,
    parameter logic [W-1:0] FAULT_XOR = 32'h0001_0100,
    parameter logic [W-1:0] TEST_VEC  = 32'h5A5A_0F0F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [W-1:0]             in_data,
    output logic                     out_valid,
    output logic [W-1:0]             out_data,
    input  logic                     diag_start,
    input  logic                     tune_start,
    input  logic [NLOG+NSPARE-1:0]   fault_inj,
    input  logic [NLOG+NSPARE-1:0]   sel_flip,
    output logic [NLOG+NSPARE-1:0]   bypass_map,
    output logic [MW-1:0]            margin,
    output logic                     busy,
    output logic                     failed
);
    localparam int NPHYS = NLOG + NSPARE;

    // Expected test result: the stage step applied NLOG times.
    function automatic logic [W-1:0] chain_ref(input logic [W-1:0] x);
        logic [W-1:0] t;
        t = x;
        for (int i = 0; i < NLOG; i++) t = ((t << ROT) | (t >> (W - ROT))) + STEP_K;
        return t;
    endfunction
    localparam logic [W-1:0] TEST_EXP = chain_ref(TEST_VEC);

    logic [NPHYS:0][W-1:0] dch;
    logic [NPHYS:0]        vch, tch;
    logic [NPHYS-1:0]      want_map;
    logic                  test_fire, pipe_empty, res_valid;

    // Chain head: test word when launching, otherwise user word when allowed.
    assign dch[0] = test_fire ? TEST_VEC : in_data;
    assign vch[0] = test_fire | (in_valid & ~busy);
    assign tch[0] = test_fire;

    for (genvar j = 0; j < NPHYS; j++) begin : g_stage
        sp_stage #(.W(W), .ROT(ROT), .STEP_K(STEP_K), .FAULT_XOR(FAULT_XOR)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .d_in (dch[j]),
            .v_in (vch[j]),
            .t_in (tch[j]),
            .byp  (bypass_map[j]),
            .fault(fault_inj[j]),
            .d_q  (dch[j+1]),
            .v_q  (vch[j+1]),
            .t_q  (tch[j+1])
        );
    end

    // Split the chain tail into user output and test result.
    assign pipe_empty = ~|vch[NPHYS:1];
    assign out_valid  = vch[NPHYS] & ~tch[NPHYS];
    assign out_data   = dch[NPHYS];
    assign res_valid  = vch[NPHYS] & tch[NPHYS];

    sp_bypass_sel #(.NPHYS(NPHYS), .NSPARE(NSPARE)) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pipe_empty),
        .want (want_map),
        .flip (sel_flip),
        .map  (bypass_map)
    );

    sp_diag_ctrl #(.W(W), .NPHYS(NPHYS), .NSPARE(NSPARE), .MW(MW),
                   .TEST_EXP(TEST_EXP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .diag_start (diag_start),
        .tune_start (tune_start),
        .pipe_empty (pipe_empty),
        .res_valid  (res_valid),
        .res_data   (dch[NPHYS]),
        .applied_map(bypass_map),
        .want_map   (want_map),
        .test_fire  (test_fire),
        .busy       (busy),
        .failed     (failed),
        .margin     (margin)
    );

    // R5: the applied map only changes after a cycle with an empty pipeline.
    p_map_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bypass_map) |-> $past(pipe_empty));

    // R3: test results only leave the chain while the controller is busy.
    p_test_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);
endmodule

// File: tb/sim_spare_pipe.sv
// Scoreboard bench: the driver pushes expected words with their entry cycle,
// and a monitor pops and compares them as outputs appear.
module sim_spare_pipe;
    localparam int NLOG  = 4;
    localparam int NSP   = 1;
    localparam int NPHYS = NLOG + NSP;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic             out_valid;
    logic [31:0]      out_data;
    logic             diag_start = 1'b0;
    logic             tune_start = 1'b0;
    logic [NPHYS-1:0] fault_inj;
    logic [NPHYS-1:0] sel_flip = '0;
    logic [NPHYS-1:0] bypass_map;
    logic [2:0]       margin;
    logic             busy, failed;

    // Bench fault model: a fixed fault set plus two margin-dependent weak sets.
    logic [NPHYS-1:0] fix_fault = '0, weak_a = '0, weak_b = '0;
    int               thr_a = 0, thr_b = 0;

    int checks = 0, fails = 0, unexpected = 0, step_err = 0;
    int cyc = 0;
    string sb_tag = "R2";
    logic [31:0] exp_q[$];
    int          stamp_q[$];
    logic [2:0]  prev_margin = 3'd7;

    always #2 clk = ~clk;

    always_comb begin
        fault_inj = fix_fault |
                    ((int'(margin) < thr_a) ? weak_a : '0) |
                    ((int'(margin) < thr_b) ? weak_b : '0);
    end

    spare_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .diag_start(diag_start),
        .tune_start(tune_start), .fault_inj(fault_inj), .sel_flip(sel_flip),
        .bypass_map(bypass_map), .margin(margin), .busy(busy), .failed(failed)
    );

    function automatic logic [31:0] ref_fn(input logic [31:0] x);
        logic [31:0] t;
        t = x;
        for (int i = 0; i < NLOG; i++) t = {t[26:0], t[31:27]} + 32'h9E37_79B9;
        return t;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // Monitor: pop and compare each output word and its latency.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                unexpected++;
            end else begin
                logic [31:0] e;
                int s;
                e = exp_q.pop_front();
                s = stamp_q.pop_front();
                chk({sb_tag, " data"}, out_data, e);
                chk({sb_tag, " latency"}, 32'(cyc - s), 32'(NPHYS));
            end
        end
        // R9 side monitor: margin moves only in single steps.
        if (rst_n && margin != prev_margin &&
            margin != prev_margin + 3'd1 && margin != prev_margin - 3'd1) step_err++;
        prev_margin = margin;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        stamp_q.delete();
        rst_n = 1'b1;
    endtask

    task automatic send_burst(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [31:0] x;
            @(negedge clk);
            x = (i == 0) ? seed : ((i == 1) ? 32'hFFFF_FFFF : seed * (i + 7) + 32'h1357);
            in_valid = 1'b1;
            in_data  = x;
            exp_q.push_back(ref_fn(x));
            stamp_q.push_back(cyc);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (NPHYS + 3) @(negedge clk);
        chk({tag, " all words returned"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Pulse a request; push in_valid while busy to show it is ignored (R3).
    task automatic request(input bit tune);
        @(negedge clk);
        if (tune) tune_start = 1'b1; else diag_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
        diag_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_valid = busy;
            in_data  = 32'hDEAD_0000 + 32'(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        wait_idle();
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 bypass_map", 32'(bypass_map), 32'b10000);
        chk("R1 margin", 32'(margin), 32'd7);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 failed", 32'(failed), 32'd0);

        // R2: normal stream, in order, fixed latency
        sb_tag = "R2";
        send_burst(6, 32'h0000_0000);
        drain("R2");

        // R5 + R6: words in flight when diagnosis starts; fault-free pipeline
        sb_tag = "R5";
        send_burst(3, 32'h1234_5678);
        request(1'b0);
        drain("R5");
        chk("R6 map unchanged", 32'(bypass_map), 32'b10000);
        chk("R6 margin unchanged", 32'(margin), 32'd7);
        chk("R6 not failed", 32'(failed), 32'd0);
        chk("R3 no stray outputs", 32'(unexpected), 32'd0);

        // R7: fault in stage 1 is located and bypassed
        fix_fault = 5'b00010;
        request(1'b0);
        chk("R7 map selects stage 1", 32'(bypass_map), 32'b00010);
        chk("R7 not failed", 32'(failed), 32'd0);
        chk("R4 spare count", 32'($countones(bypass_map)), 32'(NSP));
        sb_tag = "R7";
        send_burst(5, 32'hCAFE_0001);
        drain("R7");

        // R12: one select copy upset in every stage
        sel_flip = 5'b11111;
        @(negedge clk);
        chk("R12 map unchanged", 32'(bypass_map), 32'b00010);
        sb_tag = "R12";
        send_burst(4, 32'h0BAD_F00D);
        drain("R12");
        sel_flip = '0;

        // R8: second fault with no spare left
        fix_fault = 5'b01010;
        request(1'b0);
        chk("R8 failed", 32'(failed), 32'd1);
        chk("R8 map kept", 32'(bypass_map), 32'b00010);
        request(1'b0);
        chk("R8 still failed", 32'(failed), 32'd1);
        chk("R8 idle after request", 32'(busy), 32'd0);
        chk("R3 no stray outputs", 32'(unexpected), 32'd0);

        // R10: tuning isolates a weak stage 2 (fails below margin 5)
        fix_fault = '0;
        do_reset();
        weak_a = 5'b00100; thr_a = 5;
        request(1'b1);
        chk("R10 margin reaches 0", 32'(margin), 32'd0);
        chk("R10 map selects stage 2", 32'(bypass_map), 32'b00100);
        chk("R10 not failed", 32'(failed), 32'd0);
        sb_tag = "R10";
        send_burst(4, 32'h7777_1111);
        drain("R10");

        // R11: two weak stages, one spare: margin raised back
        do_reset();
        weak_a = 5'b00010; thr_a = 4;
        weak_b = 5'b01000; thr_b = 4;
        request(1'b1);
        chk("R11 margin raised to 4", 32'(margin), 32'd4);
        chk("R11 map unchanged", 32'(bypass_map), 32'b10000);
        chk("R11 not failed", 32'(failed), 32'd0);
        chk("R4 spare count", 32'($countones(bypass_map)), 32'(NSP));
        sb_tag = "R11";
        send_burst(4, 32'h2468_ACE0);
        drain("R11");

        chk("R9 single margin steps", 32'(step_err), 32'd0);
        chk("R3 no stray outputs", 32'(unexpected), 32'd0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule